// File: doc/BRIEF.md
# Two-Wire Paged EEPROM Slave Controller

This block is a slave on a two-wire serial bus in front of a 512-byte storage array held in flip-flops. It samples SCL and SDA in the system clock domain and finds START and STOP conditions. It checks the address byte and acknowledges each byte it accepts. It drives SDA only through an active-high pull-down enable, so the pad stays open-drain.

Masters can write one byte or a burst into a 16-byte page. Write data is held in a page staging buffer and reaches the array only when a STOP follows a completed data byte. A self-timed write cycle then starts. For its whole length the block acknowledges nothing, so a master can poll the block until it answers. Masters can read from the internal address counter, from an address they have just loaded, or run a sequential read that walks the whole array.

A second device identifier reaches a neighbouring control-register block through a write strobe and a read-data input. That block returns a write-enable flag and a 3-bit protect code, and this controller uses them, together with the write-protect pin, to decide whether each data byte is accepted.

Top module: `twi_ee_slave`

## Requirements
- R1: After reset, SDA is released, no control strobe is issued, and every array byte reads 8'hFF.
- R2: Only an address byte whose upper nibble is 4'b1010 (array) or 4'b1011 (control register), followed by bits 3:2 equal to 2'b00, is acknowledged. Bit 1 is the high address bit A8 and bit 0 selects read when 1. Any other address byte is not acknowledged, and every following byte is ignored and not acknowledged until the next START.
- R3: A write made of an address byte, a word-address byte and one data byte commits that byte at STOP. Afterwards the internal address counter points one past the last byte accessed, for both writes and reads.
- R4: During a burst write, only the low 4 address bits advance, and they wrap from 15 to 0 inside the same page. A later byte to the same location overwrites an earlier one.
- R5: A sequential read returns consecutive bytes for as long as the master acknowledges, and it wraps from address 9'h1FF to 9'h000.
- R6: A STOP that arrives inside a data byte discards the whole pending write. The array keeps its contents and no write cycle starts.
- R7: For WCYC_CYCLES clocks after a committed array write, SDA stays released and address bytes are not acknowledged. After that, an address byte is acknowledged again.
- R8: A data byte for the array is not acknowledged and not stored when the enable input is low or when its address is protected. Protect codes: 0 none; 1 addresses at or above 3/4 of the array; 2 at or above 1/2; 3 all; 4 the first page; 5 the first 2 pages; 6 the first 4 pages; 7 the first 8 pages.
- R9: While the write-protect input is high, no data byte for the array or the control register is acknowledged or stored.
- R10: A STOP issued right after the word-address byte loads the address counter without transferring data. A following current-address read returns the byte at that address.
- R11: A data byte written with the control identifier is acknowledged whatever the enable input is. It produces exactly one single-cycle strobe, carrying the byte, at the STOP, and starts no write cycle. A read with the control identifier returns the control read-data input.
- R12: The SDA pull-down changes only while SCL is low. Once the master does not acknowledge a read byte, the block drives SDA no more until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock level seen on the bus |
| sda_i | input | 1 | Serial data level seen on the bus |
| sda_oe_o | output | 1 | Pulls SDA low when 1 (open-drain enable) |
| wp_i | input | 1 | Write-protect pin; high blocks all writes |
| wel_i | input | 1 | Array write enable from the control register block |
| prot_code_i | input | 3 | Block protect code from the control register block |
| creg_rdata_i | input | 8 | Control register value returned on control reads |
| creg_wr_o | output | 1 | One-cycle strobe for a committed control register write |
| creg_wdata_o | output | 8 | Byte carried by the control register strobe |

## Verification
The hardest situations to reach from the ports lie at the edges of a transaction: a STOP that lands inside a data byte, and the window after a commit in which the block must stay silent. The stimulus reaches the first with a bit-level master task that can stop after any number of bits. It reaches the second by issuing an address poll right after the committing STOP, expecting a NACK, and then polling until the block answers. Page wrap and the array-end wrap are reached by a burst that starts in the middle of a page and by a sequential read that starts two bytes below the top address.

// File: rtl/twi_ee_pkg.sv
package twi_ee_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_WADDR,
      ST_WDATA,
      ST_RDATA,
      ST_SKIP
   } phase_e;

   // Returns 1 when the block-protect code covers the given address.
   function automatic logic prot_hit(input logic [2:0] code,
                                     input int unsigned addr,
                                     input int unsigned depth,
                                     input int unsigned page);
      logic hit;
      case (code)
         3'd1:    hit = (addr >= (depth / 4) * 3);
         3'd2:    hit = (addr >= depth / 2);
         3'd3:    hit = 1'b1;
         3'd4:    hit = (addr < page);
         3'd5:    hit = (addr < 2 * page);
         3'd6:    hit = (addr < 4 * page);
         3'd7:    hit = (addr < 8 * page);
         default: hit = 1'b0;
      endcase
      return hit;
   endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   if (STAGES < 1) begin : g_bad_stages
      $error("twi_line_sync: STAGES must be at least 1");
   end

   logic [STAGES:0] scl_sh;
   logic [STAGES:0] sda_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
      end else begin
         scl_sh <= {scl_sh[STAGES-1:0], scl_i};
         sda_sh <= {sda_sh[STAGES-1:0], sda_i};
      end
   end

   logic scl_now, scl_old, sda_now, sda_old;
   assign scl_now = scl_sh[STAGES-1];
   assign scl_old = scl_sh[STAGES];
   assign sda_now = sda_sh[STAGES-1];
   assign sda_old = sda_sh[STAGES];

   assign sda_o      = sda_now;
   assign scl_rise_o = scl_now & ~scl_old;
   assign scl_fall_o = ~scl_now & scl_old;
   assign start_o    = scl_now & scl_old & sda_old & ~sda_now;
   assign stop_o     = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/twi_page_buf.sv
module twi_page_buf #(
   parameter int PAGE_W = 4,
   parameter int DATA_W = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             clr_i,
   input  logic                             we_i,
   input  logic [PAGE_W-1:0]                idx_i,
   input  logic [DATA_W-1:0]                wdata_i,
   output logic [(1<<PAGE_W)*DATA_W-1:0]    data_o,
   output logic [(1<<PAGE_W)-1:0]           valid_o
);
   localparam int SLOTS = 1 << PAGE_W;

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic [DATA_W-1:0] byte_q;
      logic              vld_q;
      logic              hit;
      assign hit = we_i && (idx_i == PAGE_W'(s));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            byte_q <= '0;
            vld_q  <= 1'b0;
         end else if (clr_i) begin
            vld_q  <= 1'b0;
         end else if (hit) begin
            byte_q <= wdata_i;
            vld_q  <= 1'b1;
         end
      end

      assign data_o[s*DATA_W +: DATA_W] = byte_q;
      assign valid_o[s]                 = vld_q;
   end
endmodule

// File: rtl/twi_ee_array.sv
module twi_ee_array #(
   parameter int              ADDR_W = 9,
   parameter int              PAGE_W = 4,
   parameter int              DATA_W = 8,
   parameter logic [DATA_W-1:0] ERASED = '1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           commit_i,
   input  logic [ADDR_W-PAGE_W-1:0]       page_i,
   input  logic [(1<<PAGE_W)*DATA_W-1:0]  buf_data_i,
   input  logic [(1<<PAGE_W)-1:0]         buf_valid_i,
   input  logic [ADDR_W-1:0]              raddr_i,
   output logic [DATA_W-1:0]              rdata_o
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int SLOTS = 1 << PAGE_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
      end else if (commit_i) begin
         for (int j = 0; j < SLOTS; j++) begin
            if (buf_valid_i[j]) mem[{page_i, PAGE_W'(j)}] <= buf_data_i[j*DATA_W +: DATA_W];
         end
      end
   end

   assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/twi_ee_slave.sv
module twi_ee_slave
   import twi_ee_pkg::*;
#(
   parameter int         ADDR_W      = 9,
   parameter int         PAGE_W      = 4,
   parameter int         DATA_W      = 8,
   parameter int         SYNC_STAGES = 2,
   parameter int         WCYC_CYCLES = 400,
   parameter logic [3:0] ARRAY_ID    = 4'b1010,
   parameter logic [3:0] CREG_ID     = 4'b1011,
   parameter logic [7:0] ERASED      = 8'hFF
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe_o,
   input  logic       wp_i,
   input  logic       wel_i,
   input  logic [2:0] prot_code_i,
   input  logic [7:0] creg_rdata_i,
   output logic       creg_wr_o,
   output logic [7:0] creg_wdata_o
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int SLOTS = 1 << PAGE_W;
   localparam int PN_W  = ADDR_W - PAGE_W;
   localparam int WC_W  = $clog2(WCYC_CYCLES + 1);

   if (ADDR_W != 9) begin : g_bad_addr
      $error("twi_ee_slave: the address byte layout needs ADDR_W == 9");
   end
   if (DATA_W != 8) begin : g_bad_data
      $error("twi_ee_slave: bus bytes need DATA_W == 8");
   end
   if (PAGE_W < 1 || PAGE_W > 8) begin : g_bad_page
      $error("twi_ee_slave: PAGE_W must lie in 1..8");
   end
   if (WCYC_CYCLES < 1) begin : g_bad_wcyc
      $error("twi_ee_slave: WCYC_CYCLES must be positive");
   end

   // ---------------- line sampling ----------------
   logic sda_s, rise_ev, fall_ev, start_ev, stop_ev;

   twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .sda_o     (sda_s),
      .scl_rise_o(rise_ev),
      .scl_fall_o(fall_ev),
      .start_o   (start_ev),
      .stop_o    (stop_ev)
   );

   // ---------------- protocol state ----------------
   phase_e              st_q;
   logic [3:0]          bit_q;
   logic [7:0]          sh_q;
   logic [7:0]          tx_q;
   logic [ADDR_W-1:0]   ptr_q;
   logic                a_hi_q;
   logic                rd_q;
   logic                creg_q;
   logic                mack_q;
   logic                sda_oe_q;
   logic                creg_pend_q;
   logic [7:0]          creg_data_q;
   logic                creg_wr_q;
   logic                busy_q;
   logic [WC_W-1:0]     wc_q;

   logic                active;
   assign active = (st_q != ST_IDLE) && (st_q != ST_SKIP);

   // ---------------- address byte decode ----------------
   logic id_arr, id_creg, dev_ok;
   assign id_arr  = (sh_q[7:4] == ARRAY_ID);
   assign id_creg = (sh_q[7:4] == CREG_ID);
   assign dev_ok  = (id_arr || id_creg) && (sh_q[3:2] == 2'b00) && !busy_q;

   // ---------------- write gating ----------------
   logic arr_locked, wr_ok;
   assign arr_locked = prot_hit(prot_code_i, 32'(ptr_q), DEPTH, SLOTS);
   assign wr_ok      = !wp_i && (creg_q || (wel_i && !arr_locked));

   // ---------------- page staging buffer ----------------
   logic                      buf_clr, buf_we;
   logic [SLOTS*DATA_W-1:0]   buf_data;
   logic [SLOTS-1:0]          buf_valid;
   logic                      byte_done;

   assign byte_done = fall_ev && active && (bit_q == 4'd8);
   assign buf_clr   = start_ev || stop_ev;
   assign buf_we    = byte_done && (st_q == ST_WDATA) && !creg_q && wr_ok && !start_ev && !stop_ev;

   twi_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (buf_clr),
      .we_i   (buf_we),
      .idx_i  (ptr_q[PAGE_W-1:0]),
      .wdata_i(sh_q),
      .data_o (buf_data),
      .valid_o(buf_valid)
   );

   // ---------------- commit at STOP ----------------
   logic stop_ok, commit, creg_fire;
   assign stop_ok   = stop_ev && (st_q == ST_WDATA) && (bit_q <= 4'd1);
   assign commit    = stop_ok && (|buf_valid);
   assign creg_fire = stop_ok && creg_pend_q;

   logic [PN_W-1:0]   page_no;
   logic [DATA_W-1:0] arr_rdata;
   assign page_no = ptr_q[ADDR_W-1:PAGE_W];

   twi_ee_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W), .ERASED(ERASED)) u_array (
      .clk        (clk),
      .rst_n      (rst_n),
      .commit_i   (commit),
      .page_i     (page_no),
      .buf_data_i (buf_data),
      .buf_valid_i(buf_valid),
      .raddr_i    (ptr_q),
      .rdata_o    (arr_rdata)
   );

   logic [7:0] rd_byte;
   assign rd_byte = creg_q ? creg_rdata_i : arr_rdata;

   // ---------------- self-timed write cycle ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         wc_q   <= '0;
      end else if (commit) begin
         busy_q <= 1'b1;
         wc_q   <= WC_W'(WCYC_CYCLES - 1);
      end else if (busy_q) begin
         if (wc_q == '0) busy_q <= 1'b0;
         else            wc_q   <= wc_q - WC_W'(1);
      end
   end

   // ---------------- bit/byte sequencer ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         bit_q       <= '0;
         sh_q        <= '0;
         tx_q        <= '0;
         ptr_q       <= '0;
         a_hi_q      <= 1'b0;
         rd_q        <= 1'b0;
         creg_q      <= 1'b0;
         mack_q      <= 1'b0;
         sda_oe_q    <= 1'b0;
         creg_pend_q <= 1'b0;
         creg_data_q <= '0;
         creg_wr_q   <= 1'b0;
      end else begin
         creg_wr_q <= creg_fire;
         if (start_ev) begin
            st_q        <= ST_DEV;
            bit_q       <= '0;
            sda_oe_q    <= 1'b0;
            creg_pend_q <= 1'b0;
         end else if (stop_ev) begin
            st_q        <= ST_IDLE;
            bit_q       <= '0;
            sda_oe_q    <= 1'b0;
            creg_pend_q <= 1'b0;
         end else if (rise_ev && active) begin
            if (bit_q < 4'd8) sh_q <= {sh_q[6:0], sda_s};
            if (st_q == ST_RDATA && bit_q == 4'd8) mack_q <= !sda_s;
            if (bit_q < 4'd9) bit_q <= bit_q + 4'd1;
         end else if (fall_ev && active) begin
            if (bit_q == 4'd8) begin
               case (st_q)
                  ST_DEV: begin
                     if (dev_ok) begin
                        sda_oe_q <= 1'b1;
                        creg_q   <= id_creg;
                        rd_q     <= sh_q[0];
                        if (!sh_q[0]) a_hi_q <= sh_q[1];
                     end else begin
                        st_q <= ST_SKIP;
                     end
                  end
                  ST_WADDR: begin
                     sda_oe_q <= 1'b1;
                     ptr_q    <= {a_hi_q, sh_q};
                  end
                  ST_WDATA: begin
                     if (wr_ok) begin
                        sda_oe_q <= 1'b1;
                        if (creg_q) begin
                           creg_pend_q <= 1'b1;
                           creg_data_q <= sh_q;
                        end
                     end
                     if (!creg_q)
                        ptr_q <= {page_no, ptr_q[PAGE_W-1:0] + PAGE_W'(1)};
                  end
                  default: sda_oe_q <= 1'b0;
               endcase
            end else if (bit_q == 4'd9) begin
               bit_q <= '0;
               case (st_q)
                  ST_DEV: begin
                     if (rd_q) begin
                        st_q     <= ST_RDATA;
                        tx_q     <= rd_byte;
                        sda_oe_q <= !rd_byte[7];
                        if (!creg_q) ptr_q <= ptr_q + ADDR_W'(1);
                     end else begin
                        st_q     <= ST_WADDR;
                        sda_oe_q <= 1'b0;
                     end
                  end
                  ST_WADDR: begin
                     st_q     <= ST_WDATA;
                     sda_oe_q <= 1'b0;
                  end
                  ST_RDATA: begin
                     if (mack_q) begin
                        tx_q     <= rd_byte;
                        sda_oe_q <= !rd_byte[7];
                        if (!creg_q) ptr_q <= ptr_q + ADDR_W'(1);
                     end else begin
                        st_q     <= ST_SKIP;
                        sda_oe_q <= 1'b0;
                     end
                  end
                  default: sda_oe_q <= 1'b0;
               endcase
            end else if (st_q == ST_RDATA && bit_q != 4'd0) begin
               sda_oe_q <= !tx_q[3'(4'd7 - bit_q)];
            end
         end
      end
   end

   logic st_wdata;
   assign st_wdata = (st_q == ST_WDATA);

   assign sda_oe_o     = sda_oe_q;
   assign creg_wr_o    = creg_wr_q;
   assign creg_wdata_o = creg_data_q;
endmodule

// File: rtl/twi_ee_slave_chk.sv
module twi_ee_slave_chk #(
   parameter int PN_W = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic            scl_i,
   input logic            sda_oe_o,
   input logic            creg_wr_o,
   input logic            wp_i,
   input logic            busy_q,
   input logic            buf_we,
   input logic            commit,
   input logic            st_wdata,
   input logic [PN_W-1:0] page_no
);
   assert_sda_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe_o != $past(sda_oe_o)) |-> !scl_i)
      else $error("SDA pull-down changed while SCL high");

   assert_busy_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> !sda_oe_o)
      else $error("SDA driven during write cycle");

   assert_commit_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> busy_q)
      else $error("commit did not start a write cycle");

   assert_wp_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wp_i |-> !buf_we)
      else $error("byte staged while write-protect high");

   assert_creg_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      creg_wr_o |=> !creg_wr_o)
      else $error("control strobe longer than one cycle");

   assert_page_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wdata && $past(st_wdata)) |-> $stable(page_no))
      else $error("page changed during burst write");
endmodule

bind twi_ee_slave twi_ee_slave_chk #(.PN_W(ADDR_W - PAGE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_i    (scl_i),
   .sda_oe_o (sda_oe_o),
   .creg_wr_o(creg_wr_o),
   .wp_i     (wp_i),
   .busy_q   (busy_q),
   .buf_we   (buf_we),
   .commit   (commit),
   .st_wdata (st_wdata),
   .page_no  (page_no)
);

// File: tb/twi_ee_slave_bench.sv
module twi_ee_slave_bench;
   localparam int H = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe, sda_bus;
   logic wp = 1'b0, wel = 1'b1;
   logic [2:0] prot = 3'd0;
   logic [7:0] creg_rd = 8'h5C;
   logic creg_wr;
   logic [7:0] creg_wd;

   always #4 clk = ~clk;

   assign sda_bus = sda_m & ~sda_oe;

   twi_ee_slave u_twi_ee_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
      .wp_i(wp), .wel_i(wel), .prot_code_i(prot), .creg_rdata_i(creg_rd),
      .creg_wr_o(creg_wr), .creg_wdata_o(creg_wd)
   );

   int checks = 0, fails = 0;
   bit done = 0;
   int strobes = 0;
   logic [7:0] last_strobe = 8'h00;
   bit mon_en = 0;
   int mon_drv = 0;

   always @(posedge clk) begin
      if (creg_wr) begin strobes++; last_strobe = creg_wd; end
      if (mon_en && sda_oe) mon_drv++;
   end

   logic [7:0] mdl [512];
   logic [7:0] wbuf [24];
   logic [7:0] rbuf [24];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n); repeat (n) @(negedge clk); endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(2); scl = 1'b1; tick(H); sda_m = 1'b0; tick(H); scl = 1'b0; tick(2);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(H); scl = 1'b1; tick(H); sda_m = 1'b1; tick(H);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_m = b[i]; tick(H); scl = 1'b1; tick(H); scl = 1'b0; tick(2);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      send_bits(b, 8);
      sda_m = 1'b1; tick(H); scl = 1'b1; tick(H/2); ack = !sda_bus; tick(H/2); scl = 1'b0; tick(2);
   endtask

   task automatic recv_byte(input logic mack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         tick(H); scl = 1'b1; tick(H/2); b[i] = sda_bus; tick(H/2); scl = 1'b0; tick(2);
      end
      sda_m = !mack; tick(H); scl = 1'b1; tick(H); scl = 1'b0; tick(2); sda_m = 1'b1;
   endtask

   function automatic logic [7:0] dev(input logic [3:0] id, input logic [8:0] a, input logic rd);
      return {id, 2'b00, a[8], rd};
   endfunction

   // write n bytes of wbuf starting at a; returns address ack and count of acked data bytes
   task automatic ee_write(input logic [3:0] id, input logic [8:0] a, input int n,
                           output logic dack, output int nack_ok);
      logic k;
      nack_ok = 0;
      bus_start();
      send_byte(dev(id, a, 1'b0), dack);
      send_byte(a[7:0], k);
      for (int i = 0; i < n; i++) begin
         send_byte(wbuf[i], k);
         if (k) nack_ok++;
      end
      bus_stop();
   endtask

   task automatic ee_rand_read(input logic [3:0] id, input logic [8:0] a, input int n);
      logic k;
      bus_start();
      send_byte(dev(id, a, 1'b0), k);
      send_byte(a[7:0], k);
      bus_start();
      send_byte(dev(id, 9'h0, 1'b1), k);
      for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
      bus_stop();
   endtask

   task automatic ee_cur_read(input int n);
      logic k;
      bus_start();
      send_byte(dev(4'b1010, 9'h0, 1'b1), k);
      for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
      bus_stop();
   endtask

   task automatic poll(output logic ack);
      bus_start(); send_byte(dev(4'b1010, 9'h0, 1'b0), ack); bus_stop();
   endtask

   task automatic wait_ready(output logic ok);
      logic a;
      ok = 1'b0;
      for (int i = 0; i < 30 && !ok; i++) begin
         poll(a);
         if (a) ok = 1'b1;
      end
   endtask

   typedef struct packed {
      logic [8:0] addr;
      logic [7:0] data;
      logic       en;
      logic [2:0] pc;
      logic       wpin;
      logic       ack;
   } vec_t;

   localparam vec_t VEC [12] = '{
      '{9'h005, 8'h3C, 1'b1, 3'd0, 1'b0, 1'b1},
      '{9'h1F0, 8'hA5, 1'b1, 3'd0, 1'b0, 1'b1},
      '{9'h123, 8'h11, 1'b0, 3'd0, 1'b0, 1'b0},
      '{9'h190, 8'h22, 1'b1, 3'd1, 1'b0, 1'b0},
      '{9'h170, 8'h33, 1'b1, 3'd1, 1'b0, 1'b1},
      '{9'h010, 8'h44, 1'b1, 3'd4, 1'b0, 1'b1},
      '{9'h00F, 8'h55, 1'b1, 3'd4, 1'b0, 1'b0},
      '{9'h07F, 8'h66, 1'b1, 3'd7, 1'b0, 1'b0},
      '{9'h080, 8'h77, 1'b1, 3'd7, 1'b0, 1'b1},
      '{9'h0AA, 8'h88, 1'b1, 3'd0, 1'b1, 1'b0},
      '{9'h0FF, 8'h99, 1'b1, 3'd2, 1'b0, 1'b1},
      '{9'h100, 8'h12, 1'b1, 3'd2, 1'b0, 1'b0}
   };

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic da, ok, p;
      int na;
      for (int i = 0; i < 512; i++) mdl[i] = 8'hFF;
      tick(10);
      rst_n = 1'b1;
      tick(5);

      // R1: reset state
      chk("R1 sda released", sda_oe, 1'b0);
      chk("R1 no strobe", strobes, 0);
      ee_rand_read(4'b1010, 9'h000, 1);
      chk("R1 erased byte", rbuf[0], 8'hFF);

      // table walk: R3, R8, R9
      foreach (VEC[v]) begin
         wel = VEC[v].en; prot = VEC[v].pc; wp = VEC[v].wpin;
         wbuf[0] = VEC[v].data;
         ee_write(4'b1010, VEC[v].addr, 1, da, na);
         chk("R3 address ack", da, 1'b1);
         chk(VEC[v].wpin ? "R9 data ack" : "R8 data ack", na, VEC[v].ack ? 1 : 0);
         if (VEC[v].ack) mdl[VEC[v].addr] = VEC[v].data;
         wait_ready(ok);
         chk("R7 ready", ok, 1'b1);
         wel = 1'b1; prot = 3'd0; wp = 1'b0;
         ee_rand_read(4'b1010, VEC[v].addr, 1);
         chk("R3 readback", rbuf[0], mdl[VEC[v].addr]);
         ee_cur_read(1);
         chk("R3 counter past last", rbuf[0], mdl[9'(VEC[v].addr + 9'd1)]);
      end

      // R7: silent right after commit, then answers
      wbuf[0] = 8'h5A;
      ee_write(4'b1010, 9'h1FF, 1, da, na);
      mdl[9'h1FF] = 8'h5A;
      poll(p);
      chk("R7 busy nack", p, 1'b0);
      wait_ready(ok);
      chk("R7 ack after cycle", ok, 1'b1);
      wbuf[0] = 8'h6B;
      ee_write(4'b1010, 9'h000, 1, da, na);
      mdl[9'h000] = 8'h6B;
      wait_ready(ok);

      // R5: sequential read across top of array
      ee_rand_read(4'b1010, 9'h1FE, 4);
      chk("R5 seq 1FE", rbuf[0], mdl[9'h1FE]);
      chk("R5 seq 1FF", rbuf[1], 8'h5A);
      chk("R5 wrap 000", rbuf[2], 8'h6B);
      chk("R5 wrap 001", rbuf[3], mdl[9'h001]);

      // R4: 20-byte burst from mid-page wraps and overwrites
      for (int i = 0; i < 20; i++) begin
         wbuf[i] = 8'hC0 + 8'(i);
         mdl[{5'h04, 4'(4'hA + i)}] = 8'hC0 + 8'(i);
      end
      ee_write(4'b1010, 9'h04A, 20, da, na);
      chk("R4 all acked", na, 20);
      wait_ready(ok);
      ee_cur_read(1);
      chk("R4 counter after burst", rbuf[0], mdl[9'h04E]);
      ee_rand_read(4'b1010, 9'h040, 17);
      for (int i = 0; i < 16; i++) chk("R4 page content", rbuf[i], mdl[9'h040 + 9'(i)]);
      chk("R4 next page untouched", rbuf[16], mdl[9'h050]);

      // R6: STOP inside second data byte discards the write
      bus_start();
      send_byte(dev(4'b1010, 9'h030, 1'b0), da);
      send_byte(8'h30, da);
      send_byte(8'h12, da);
      chk("R6 first data acked", da, 1'b1);
      send_bits(8'hF0, 4);
      bus_stop();
      poll(p);
      chk("R6 no write cycle", p, 1'b1);
      ee_rand_read(4'b1010, 9'h030, 1);
      chk("R6 array unchanged", rbuf[0], mdl[9'h030]);

      // R2: wrong identifier and bad fixed bits
      bus_start();
      send_byte(8'h90, da);
      chk("R2 bad id nack", da, 1'b0);
      send_byte(8'h20, da);
      chk("R2 ignored after bad id", da, 1'b0);
      send_byte(8'h01, da);
      bus_stop();
      bus_start();
      send_byte(8'hA4, da);
      chk("R2 nonzero fixed bits nack", da, 1'b0);
      bus_stop();
      ee_rand_read(4'b1010, 9'h020, 1);
      chk("R2 no write happened", rbuf[0], mdl[9'h020]);

      // R10: set current address
      bus_start();
      send_byte(dev(4'b1010, 9'h1F0, 1'b0), da);
      send_byte(8'hF0, da);
      bus_stop();
      poll(p);
      chk("R10 no write cycle", p, 1'b1);
      ee_cur_read(1);
      chk("R10 loaded address", rbuf[0], 8'hA5);

      // R11: control register path, enable low has no effect
      wel = 1'b0;
      wbuf[0] = 8'h06;
      ee_write(4'b1011, 9'h1FF, 1, da, na);
      chk("R11 ctrl ack", na, 1);
      chk("R11 one strobe", strobes, 1);
      chk("R11 strobe data", last_strobe, 8'h06);
      poll(p);
      chk("R11 no write cycle", p, 1'b1);
      wel = 1'b1;
      ee_rand_read(4'b1011, 9'h1FF, 1);
      chk("R11 ctrl read", rbuf[0], 8'h5C);

      // R9: write-protect pin blocks control writes too
      wp = 1'b1;
      wbuf[0] = 8'h02;
      ee_write(4'b1011, 9'h1FF, 1, da, na);
      chk("R9 ctrl nack", na, 0);
      chk("R9 no strobe", strobes, 1);
      wp = 1'b0;

      // R12: silent after master NACK on a read
      bus_start();
      send_byte(dev(4'b1010, 9'h005, 1'b0), da);
      send_byte(8'h05, da);
      bus_start();
      send_byte(dev(4'b1010, 9'h0, 1'b1), da);
      recv_byte(1'b0, rbuf[0]);
      chk("R12 data before nack", rbuf[0], 8'h3C);
      mon_en = 1;
      recv_byte(1'b0, rbuf[1]);
      mon_en = 0;
      bus_stop();
      chk("R12 no drive after nack", mon_drv, 0);
      chk("R12 bus high after nack", rbuf[1], 8'hFF);

      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule